// File: doc/BRIEF.md
# Maskable Interrupt Priority Acceptance Controller

This block decides when a pending maskable interrupt request may be taken. It also keeps a record of which priority levels are in service. Up to eight request sources feed it. Each source has a 3-bit priority level, where level 0 is the most urgent. A request is held pending until the controller grants it. A grant happens only when the interrupt-disable flag is clear and the request's level is more urgent than every level already in service.

The in-service record has one bit per level. A grant sets the bit for the granted level and sets the disable flag at the same time. A return from maskable processing clears only the most urgent in-service bit. Returns from non-maskable or exception processing leave the record unchanged. The disable flag is also controlled by disable and enable events, and by returns and explicit status loads that supply a value for it. The flag is exported as bit 5 of a 32-bit status word.

Non-maskable requests are acknowledged without regard to the flag. Vector fetch and context saving are done elsewhere.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset the in-service register reads 00H, nothing is pending, no grant is signalled and the status word reads 00000020H (flag set).
- R2: Raising a request bit makes it pending from the next cycle. While the disable flag is 1, no grant occurs and the request stays pending.
- R3: When the flag is 0, the pending request with the lowest level number is granted. Among requests with equal level, the lowest index wins. The grant is a one-cycle pulse that carries the index and level, and the granted pending bit clears in the same cycle.
- R4: A grant sets the in-service bit at the granted level and sets the disable flag to 1.
- R5: A request is eligible only if its level number is strictly lower than the lowest set in-service bit position. All requests are eligible when no bit is set.
- R6: A return with kind 0 (maskable) clears only the lowest-numbered set in-service bit.
- R7: A return with kind 1 (non-maskable) or kind 2 (exception) leaves the in-service register unchanged.
- R8: When several events affect the flag in one cycle, they are resolved in this order of precedence:
  - a grant sets the flag;
  - otherwise a return or status load writes the supplied value;
  - otherwise a disable event sets the flag;
  - otherwise an enable event clears it.
  
  The grant decision uses the flag value held before the cycle.
- R9: A non-maskable request is acknowledged in the next cycle for any flag value. It changes neither the flag nor the in-service register.
- R10: When a maskable return and a grant decision fall in the same cycle, the eligibility check uses the in-service register after the return has cleared its bit.
- R11: The status word carries the flag at bit 5 and zeros in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | 8 | Request raise pulses, one per source |
| req_lvl | input | 24 | Level of source i at bits [3i+2:3i] |
| di_evt | input | 1 | Disable event |
| ei_evt | input | 1 | Enable event |
| ret_evt | input | 1 | Return event |
| ret_kind | input | 2 | 0 maskable, 1 non-maskable, 2 exception |
| ld_evt | input | 1 | Explicit status load |
| dis_src | input | 1 | Flag value supplied by a return or load |
| nm_req | input | 1 | Non-maskable request |
| acc_vld | output | 1 | Grant pulse |
| acc_idx | output | 3 | Granted source index |
| acc_lvl | output | 3 | Granted level |
| isr | output | 8 | In-service register |
| pend | output | 8 | Pending request flags |
| dis_flag | output | 1 | Interrupt-disable flag |
| stat_word | output | 32 | Status word with the flag at bit 5 |
| nm_ack | output | 1 | Non-maskable acknowledge |

## Verification
The assertions assume three things about the inputs:
- `ret_kind` holds one of the three defined codes whenever `ret_evt` is high;
- request levels stay stable while a request is pending;
- a source is not raised again in the same cycle it is granted, except where the pending check explicitly allows for it.

The stimulus table keeps to these limits. It holds the level map fixed for the whole run and uses only the three return codes.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  typedef enum logic [1:0] {
    RET_MASKABLE = 2'd0,
    RET_NONMASK  = 2'd1,
    RET_EXCEPT   = 2'd2
  } ret_kind_e;
endpackage

// File: rtl/irq_isr_track.sv
module irq_isr_track #(
  parameter int NUM_LVL = 8,
  parameter int LVL_W   = 3,
  localparam int THR_W  = LVL_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ret_mask,
  input  logic               acc_fire,
  input  logic [LVL_W-1:0]   acc_lvl,
  output logic [NUM_LVL-1:0] isr_q,
  output logic [THR_W-1:0]   thr
);
  logic [NUM_LVL-1:0] lowest_oh;
  logic [NUM_LVL-1:0] isr_upd;
  logic [NUM_LVL-1:0] set_oh;

  // isolate most urgent in-service bit, dropped by a maskable return first
  assign lowest_oh = isr_q & (~isr_q + NUM_LVL'(1));
  assign isr_upd   = ret_mask ? (isr_q & ~lowest_oh) : isr_q;
  assign set_oh    = acc_fire ? (NUM_LVL'(1) << acc_lvl) : '0;

  always_comb begin
    thr = THR_W'(NUM_LVL);
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (isr_upd[l]) thr = THR_W'(l);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) isr_q <= '0;
    else     isr_q <= isr_upd | set_oh;
  end
endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
  parameter int NUM_REQ = 8,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int THR_W  = LVL_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_REQ-1:0]       req_set,
  input  logic [NUM_REQ*LVL_W-1:0] req_lvl,
  input  logic [THR_W-1:0]         thr,
  input  logic                     enable,
  output logic [NUM_REQ-1:0]       pend_q,
  output logic                     fire,
  output logic [IDX_W-1:0]         win_idx,
  output logic [LVL_W-1:0]         win_lvl
);
  logic               found;
  logic [NUM_REQ-1:0] grant_oh;

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (pend_q[i] && ({1'b0, req_lvl[i*LVL_W +: LVL_W]} < thr) &&
          (!found || (req_lvl[i*LVL_W +: LVL_W] < win_lvl))) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = req_lvl[i*LVL_W +: LVL_W];
      end
    end
  end

  assign fire     = found && enable;
  assign grant_oh = fire ? (NUM_REQ'(1) << win_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~grant_oh) | req_set;
  end
endmodule

// File: rtl/irq_dis_flag.sv
module irq_dis_flag (
  input  logic clk,
  input  logic rst,
  input  logic acc_fire,
  input  logic wr_evt,
  input  logic wr_val,
  input  logic di_evt,
  input  logic ei_evt,
  output logic dis_q
);
  always_ff @(posedge clk) begin
    if (rst)           dis_q <= 1'b1;
    else if (acc_fire) dis_q <= 1'b1;
    else if (wr_evt)   dis_q <= wr_val;
    else if (di_evt)   dis_q <= 1'b1;
    else if (ei_evt)   dis_q <= 1'b0;
  end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl #(
  parameter int NUM_REQ = 8,
  parameter int LVL_W   = 3,
  parameter int STAT_W  = 32,
  parameter int DIS_BIT = 5,
  localparam int NUM_LVL = 1 << LVL_W,
  localparam int IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int THR_W   = LVL_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_REQ-1:0]       req_set,
  input  logic [NUM_REQ*LVL_W-1:0] req_lvl,
  input  logic                     di_evt,
  input  logic                     ei_evt,
  input  logic                     ret_evt,
  input  logic [1:0]               ret_kind,
  input  logic                     ld_evt,
  input  logic                     dis_src,
  input  logic                     nm_req,
  output logic                     acc_vld,
  output logic [IDX_W-1:0]         acc_idx,
  output logic [LVL_W-1:0]         acc_lvl,
  output logic [NUM_LVL-1:0]       isr,
  output logic [NUM_REQ-1:0]       pend,
  output logic                     dis_flag,
  output logic [STAT_W-1:0]        stat_word,
  output logic                     nm_ack
);
  import irq_accept_pkg::*;

  logic             ret_mask;
  logic [THR_W-1:0] thr;
  logic             fire;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl;

  assign ret_mask = ret_evt && (ret_kind_e'(ret_kind) == RET_MASKABLE);

  irq_isr_track #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_isr (
    .clk(clk), .rst(rst), .ret_mask(ret_mask), .acc_fire(fire),
    .acc_lvl(win_lvl), .isr_q(isr), .thr(thr)
  );

  irq_pend_arb #(.NUM_REQ(NUM_REQ), .LVL_W(LVL_W)) u_arb (
    .clk(clk), .rst(rst), .req_set(req_set), .req_lvl(req_lvl),
    .thr(thr), .enable(!dis_flag), .pend_q(pend), .fire(fire),
    .win_idx(win_idx), .win_lvl(win_lvl)
  );

  irq_dis_flag u_flag (
    .clk(clk), .rst(rst), .acc_fire(fire), .wr_evt(ret_evt || ld_evt),
    .wr_val(dis_src), .di_evt(di_evt), .ei_evt(ei_evt), .dis_q(dis_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_vld <= 1'b0;
      acc_idx <= '0;
      acc_lvl <= '0;
      nm_ack  <= 1'b0;
    end else begin
      acc_vld <= fire;
      acc_idx <= fire ? win_idx : '0;
      acc_lvl <= fire ? win_lvl : '0;
      nm_ack  <= nm_req;
    end
  end

  always_comb begin
    stat_word          = '0;
    stat_word[DIS_BIT] = dis_flag;
  end
endmodule

// File: rtl/irq_accept_ctrl_chk.sv
module irq_accept_ctrl_chk #(
  parameter int NUM_REQ = 8,
  parameter int LVL_W   = 3,
  localparam int NUM_LVL = 1 << LVL_W,
  localparam int IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_REQ-1:0] req_set,
  input logic               ret_evt,
  input logic [1:0]         ret_kind,
  input logic               nm_req,
  input logic               acc_vld,
  input logic [IDX_W-1:0]   acc_idx,
  input logic [LVL_W-1:0]   acc_lvl,
  input logic [NUM_LVL-1:0] isr,
  input logic [NUM_REQ-1:0] pend,
  input logic               dis_flag,
  input logic               nm_ack
);
  logic [NUM_REQ-1:0] req_set_d;
  always_ff @(posedge clk) req_set_d <= req_set;

  AST_NO_ACC_WHEN_DIS: assert property (@(posedge clk) disable iff (rst)
    acc_vld |-> !$past(dis_flag)); // R2
  AST_ACC_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    acc_vld |=> !acc_vld); // R3
  AST_ACC_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
    acc_vld |-> (!pend[acc_idx] || req_set_d[acc_idx])); // R3
  AST_ACC_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
    acc_vld |-> isr[acc_lvl]); // R4
  AST_ACC_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    acc_vld |-> dis_flag); // R4
  AST_RET_CLEARS_ONE: assert property (@(posedge clk) disable iff (rst)
    (ret_evt && ret_kind == 2'd0 && isr != '0) |=>
      ($countones(isr) == $countones($past(isr)) - 1 + (acc_vld ? 1 : 0))); // R6
  AST_RET_OTHER_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (ret_evt && ret_kind != 2'd0) |=> (acc_vld || $stable(isr))); // R7
  AST_NM_ACK: assert property (@(posedge clk) disable iff (rst)
    nm_req |=> nm_ack); // R9
endmodule

bind irq_accept_ctrl irq_accept_ctrl_chk #(.NUM_REQ(NUM_REQ), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .req_set(req_set), .ret_evt(ret_evt),
  .ret_kind(ret_kind), .nm_req(nm_req), .acc_vld(acc_vld),
  .acc_idx(acc_idx), .acc_lvl(acc_lvl), .isr(isr), .pend(pend),
  .dis_flag(dis_flag), .nm_ack(nm_ack)
);

// File: tb/irq_accept_ctrl_bench.sv
module irq_accept_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  req_set = '0;
  logic [23:0] req_lvl;
  logic        di_evt = 1'b0, ei_evt = 1'b0, ret_evt = 1'b0, ld_evt = 1'b0;
  logic [1:0]  ret_kind = '0;
  logic        dis_src = 1'b0, nm_req = 1'b0;
  logic        acc_vld, dis_flag, nm_ack;
  logic [2:0]  acc_idx, acc_lvl;
  logic [7:0]  isr, pend;
  logic [31:0] stat_word;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // levels: idx0=3 idx1=5 idx2=1 idx3=1 idx4=6 idx5=0 idx6=7 idx7=2
  assign req_lvl = {3'd2, 3'd7, 3'd0, 3'd6, 3'd1, 3'd1, 3'd5, 3'd3};

  irq_accept_ctrl u_irq_accept_ctrl (
    .clk(clk), .rst(rst), .req_set(req_set), .req_lvl(req_lvl),
    .di_evt(di_evt), .ei_evt(ei_evt), .ret_evt(ret_evt), .ret_kind(ret_kind),
    .ld_evt(ld_evt), .dis_src(dis_src), .nm_req(nm_req), .acc_vld(acc_vld),
    .acc_idx(acc_idx), .acc_lvl(acc_lvl), .isr(isr), .pend(pend),
    .dis_flag(dis_flag), .stat_word(stat_word), .nm_ack(nm_ack)
  );

  typedef struct packed {
    logic [7:0] rs; logic di; logic ei; logic rt; logic [1:0] rk;
    logic ld; logic sb; logic nm;
    logic xa; logic [2:0] xi; logic [2:0] xl; logic [7:0] xisr;
    logic xf; logic [7:0] xp; logic xn; logic [3:0] rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{8'h05,0,0,0,2'd0,0,0,0, 0,3'd0,3'd0,8'h00,1,8'h05,0,4'd2},  // R2 raise while disabled
    '{8'h00,0,0,0,2'd0,0,0,0, 0,3'd0,3'd0,8'h00,1,8'h05,0,4'd2},  // R2 stays pending
    '{8'h00,0,1,0,2'd0,0,0,0, 0,3'd0,3'd0,8'h00,0,8'h05,0,4'd8},  // R8 enable
    '{8'h00,0,0,0,2'd0,0,0,0, 1,3'd2,3'd1,8'h02,1,8'h01,0,4'd3},  // R3 most urgent
    '{8'h00,0,1,0,2'd0,0,0,0, 0,3'd0,3'd0,8'h02,0,8'h01,0,4'd3},  // R3 one pulse
    '{8'h00,0,0,0,2'd0,0,0,0, 0,3'd0,3'd0,8'h02,0,8'h01,0,4'd5},  // R5 level 3 blocked by 1
    '{8'h20,0,0,0,2'd0,0,0,0, 0,3'd0,3'd0,8'h02,0,8'h21,0,4'd2},  // R2 raise level 0
    '{8'h00,0,0,0,2'd0,0,0,0, 1,3'd5,3'd0,8'h03,1,8'h01,0,4'd5},  // R5 nested grant
    '{8'h00,0,0,1,2'd0,0,0,0, 0,3'd0,3'd0,8'h02,0,8'h01,0,4'd6},  // R6 clears bit 0 only
    '{8'h00,0,0,1,2'd0,0,0,0, 1,3'd0,3'd3,8'h08,1,8'h00,0,4'd10}, // R10 return then grant
    '{8'h00,0,0,1,2'd2,0,0,0, 0,3'd0,3'd0,8'h08,0,8'h00,0,4'd7},  // R7 exception return
    '{8'h00,0,0,1,2'd1,0,1,0, 0,3'd0,3'd0,8'h08,1,8'h00,0,4'd7},  // R7 non-maskable return
    '{8'h00,0,0,0,2'd0,1,0,0, 0,3'd0,3'd0,8'h08,0,8'h00,0,4'd8},  // R8 load
    '{8'h8C,1,0,0,2'd0,0,0,0, 0,3'd0,3'd0,8'h08,1,8'h8C,0,4'd8},  // R8 disable
    '{8'h00,1,1,0,2'd0,0,0,0, 0,3'd0,3'd0,8'h08,1,8'h8C,0,4'd8},  // R8 disable beats enable
    '{8'h00,1,0,0,2'd0,1,0,0, 0,3'd0,3'd0,8'h08,0,8'h8C,0,4'd8},  // R8 load beats disable
    '{8'h00,0,0,0,2'd0,0,0,0, 1,3'd2,3'd1,8'h0A,1,8'h88,0,4'd3},  // R3 tie to lower index
    '{8'h00,0,0,0,2'd0,0,0,1, 0,3'd0,3'd0,8'h0A,1,8'h88,1,4'd9},  // R9 ack while disabled
    '{8'h00,0,1,1,2'd0,0,1,0, 0,3'd0,3'd0,8'h08,1,8'h88,0,4'd8},  // R8 return beats enable
    '{8'h00,0,1,0,2'd0,0,0,0, 0,3'd0,3'd0,8'h08,0,8'h88,0,4'd8},  // R8 enable
    '{8'h00,0,0,0,2'd0,0,0,0, 1,3'd3,3'd1,8'h0A,1,8'h80,0,4'd3},  // R3 next of tie
    '{8'h00,0,1,0,2'd0,0,0,0, 0,3'd0,3'd0,8'h0A,0,8'h80,0,4'd8},  // R8 enable
    '{8'h00,0,0,1,2'd0,0,0,0, 1,3'd7,3'd2,8'h0C,1,8'h00,0,4'd8},  // R8 grant beats return
    '{8'h00,0,0,0,2'd0,0,0,1, 0,3'd0,3'd0,8'h0C,1,8'h00,1,4'd9}   // R9 ack, no side effect
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_set = '0; di_evt = 0; ei_evt = 0; ret_evt = 0; ret_kind = '0;
    ld_evt = 0; dis_src = 0; nm_req = 0;
  endtask

  task automatic check_reset_state();
    chk(isr == 8'h00, "R1", "isr", 32'(isr), 32'h0);
    chk(pend == 8'h00, "R1", "pend", 32'(pend), 32'h0);
    chk(acc_vld == 1'b0, "R1", "acc_vld", 32'(acc_vld), 32'h0);
    chk(stat_word == 32'h20, "R1", "stat_word", stat_word, 32'h20);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    for (int k = 0; k < NV; k++) begin
      req_set = TBL[k].rs; di_evt = TBL[k].di; ei_evt = TBL[k].ei;
      ret_evt = TBL[k].rt; ret_kind = TBL[k].rk; ld_evt = TBL[k].ld;
      dis_src = TBL[k].sb; nm_req = TBL[k].nm;
      @(negedge clk);
      idle_inputs();
      begin
        string rq;
        rq = $sformatf("R%0d v%0d", TBL[k].rq, k);
        chk(acc_vld == TBL[k].xa, rq, "acc_vld", 32'(acc_vld), 32'(TBL[k].xa));
        if (TBL[k].xa) begin
          chk(acc_idx == TBL[k].xi, rq, "acc_idx", 32'(acc_idx), 32'(TBL[k].xi));
          chk(acc_lvl == TBL[k].xl, rq, "acc_lvl", 32'(acc_lvl), 32'(TBL[k].xl));
        end
        chk(isr == TBL[k].xisr, rq, "isr", 32'(isr), 32'(TBL[k].xisr));
        chk(dis_flag == TBL[k].xf, rq, "dis_flag", 32'(dis_flag), 32'(TBL[k].xf));
        chk(pend == TBL[k].xp, rq, "pend", 32'(pend), 32'(TBL[k].xp));
        chk(nm_ack == TBL[k].xn, rq, "nm_ack", 32'(nm_ack), 32'(TBL[k].xn));
      end
    end
    // R11: status word with flag set then clear
    chk(stat_word == 32'h20, "R11", "stat_word set", stat_word, 32'h20);
    ld_evt = 1; dis_src = 0;
    @(negedge clk);
    idle_inputs();
    chk(stat_word == 32'h0, "R11", "stat_word clear", stat_word, 32'h0);
    // R5: with isr 0C, level 2 is in service; level 2 request must wait
    req_set = 8'h80;
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    chk(acc_vld == 1'b0, "R5", "equal level blocked", 32'(acc_vld), 32'h0);
    chk(pend == 8'h80, "R5", "pend held", 32'(pend), 32'h80);
    // R1: mid-run reset returns everything to reset values
    rst = 1'b1;
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule